// File: doc/BRIEF.md
# Interrupt Entry, Exit and Tail-Chain Sequencer

This block times the hardware side of taking and leaving an interrupt on a small processor core. An external arbiter raises `irq_pend` when an interrupt is eligible to run. The arbiter has already decided priority, so the sequencer never chooses between interrupts. When a request is accepted, the sequencer waits until `instr_busy` shows that the current multi-cycle instruction has finished. It then writes an eight-word context frame to a stack memory port, spends a fixed vector-fetch interval, and pulses `hdl_start`. From an idle core with no instruction in flight, the whole entry takes 12 cycles.

When the handler signals `hdl_ret`, one of two things happens:
- If `irq_pend` is low, the frame is read back and the stack pointer rises by eight words.
- If `irq_pend` is high, the sequencer tail-chains. It goes straight to the next handler after 6 cycles, with no memory traffic, and the stack pointer is left alone.

A request that arrives while a frame is being read back abandons the read-back and becomes a tail-chain. A request seen while a handler runs causes a nested entry: a second frame is pushed below the first, and frames are popped in last-in-first-out order. `lat_cnt` reports the cycles from the accepting edge to handler start.

States:
- ST_IDLE: no handler is active.
- ST_WAIT: an instruction is still in flight.
- ST_STACK: the context words are being pushed.
- ST_FETCH: the vector-fetch interval.
- ST_RUN: a handler is executing.
- ST_UNSTK: the context words are being popped.
- ST_CHAIN: the tail-chain interval.

Transitions:
- accept: ST_IDLE or ST_RUN to ST_WAIT or ST_STACK.
- go: ST_WAIT to ST_STACK.
- push done: ST_STACK to ST_FETCH.
- enter: ST_FETCH or ST_CHAIN to ST_RUN.
- return: ST_RUN to ST_UNSTK.
- chain: ST_RUN to ST_CHAIN.
- abandon: ST_UNSTK to ST_CHAIN.
- pop done: ST_UNSTK to ST_IDLE or ST_RUN.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `hdl_start`, `mem_we` and `mem_re` are 0, `nest_depth` is 0, `lat_cnt` is 0, and `sp` equals SP_INIT.
- R2: A request accepted from idle with `instr_busy` low is followed by exactly 8 write cycles in a row. They run from address sp-8 up to sp-1, with `ctx_idx` 0 to 7 and `mem_wdata` equal to `ctx_wdata`. `hdl_start` then pulses, and `lat_cnt` reads 12.
- R3: While `instr_busy` is sampled high from the accepting edge on, no write occurs. Each such sample adds one cycle, so the latency is 12 plus the number of high samples.
- R4: `sp` falls by 8 on the edge that ends a push and rises by 8 on the edge that ends a complete pop. It never changes in any other cycle, tail-chains included.
- R5: `hdl_ret` with `irq_pend` low gives 8 read cycles in a row, from address sp up to sp+7. At nesting depth 1 the block then returns to idle. At greater depth it resumes the outer handler without an `hdl_start` pulse.
- R6: `hdl_ret` with `irq_pend` high tail-chains. There is no memory access, `hdl_start` pulses 6 cycles later, `lat_cnt` reads 6, and `sp` is unchanged.
- R7: `irq_pend` sampled high during a pop abandons the pop and tail-chains. `lat_cnt` reads 6, and `sp` and `nest_depth` keep their values from before the pop.
- R8: `irq_pend` seen while a handler runs below depth NEST_MAX pushes a new frame 8 words below the current one and raises `nest_depth`. Returns pop frames in last-in-first-out order.
- R9: `busy` is high exactly in ST_WAIT, ST_STACK, ST_FETCH, ST_UNSTK and ST_CHAIN. `hdl_start` is a single-cycle pulse in the first running cycle, and in that cycle `busy` is low.
- R10: `hdl_ret` has no effect outside ST_RUN. `irq_pend` is ignored in ST_RUN at depth NEST_MAX unless `hdl_ret` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | 1 | An eligible interrupt is waiting |
| instr_busy | input | 1 | A multi-cycle instruction is in flight |
| hdl_ret | input | 1 | The running handler returns |
| ctx_wdata | input | DW | Context word selected by `ctx_idx` |
| busy | output | 1 | The sequencer is in a transfer or wait state |
| hdl_start | output | 1 | Pulse in the first cycle of a handler |
| sp | output | AW | Stack pointer, in words |
| lat_cnt | output | LAT_W | Cycles from accept to the last handler start |
| nest_depth | output | clog2(NEST_MAX+1) | Number of frames on the stack |
| ctx_idx | output | clog2(CTX_WORDS) | Context word being transferred |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | AW | Stack word address |
| mem_wdata | output | DW | Stack write data |

## Verification
- **Pushes.** The first push is visible in the cycle that follows the accepting edge, and each later push one cycle after the previous one.
- **Stack pointer.** `sp` and `nest_depth` move on the edge that completes the 8th transfer.
- **Handler start.** `hdl_start` shows up 12 edges after accept, plus one per busy sample, or 6 edges after a tail-chain or an abandoned pop.
- **Comparison.** A behavioural model updates on the same rising edge as the design, and every output is compared with it at the following falling edge. Named checks read the latency, pointer and strobe counts only after the pulse or idle state they depend on has appeared.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_STACK,
        ST_FETCH,
        ST_RUN,
        ST_UNSTK,
        ST_CHAIN
    } seq_state_e;

endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int CTX_WORDS = 8,
    parameter int FETCH_CYC = 4,
    parameter int CHAIN_CYC = 6,
    parameter int NEST_MAX  = 4,
    parameter int CW        = 4,
    parameter int DPW       = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           irq_pend,
    input  logic           instr_busy,
    input  logic           hdl_ret,
    output seq_state_e     state,
    output logic [CW-1:0]  cnt,
    output logic [DPW-1:0] depth,
    output logic           ev_accept,
    output logic           ev_push_done,
    output logic           ev_pop_done,
    output logic           hdl_start
);

    localparam logic [CW-1:0]  LAST_CTX   = CW'(CTX_WORDS - 1);
    localparam logic [CW-1:0]  LAST_FETCH = CW'(FETCH_CYC - 1);
    localparam logic [CW-1:0]  LAST_CHAIN = CW'(CHAIN_CYC - 1);
    localparam logic [DPW-1:0] DEPTH_TOP  = DPW'(NEST_MAX);
    localparam logic [DPW-1:0] DEPTH_ONE  = DPW'(1);

    seq_state_e    nxt;
    logic [CW-1:0] nxt_cnt;
    logic          ev_enter;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            depth     <= '0;
            hdl_start <= 1'b0;
        end else begin
            state     <= nxt;
            cnt       <= nxt_cnt;
            hdl_start <= ev_enter;
            if (ev_push_done && !ev_pop_done) depth <= depth + DEPTH_ONE;
            else if (ev_pop_done && !ev_push_done) depth <= depth - DEPTH_ONE;
        end
    end

    // next-state and event process
    always_comb begin
        nxt          = state;
        nxt_cnt      = cnt;
        ev_accept    = 1'b0;
        ev_push_done = 1'b0;
        ev_pop_done  = 1'b0;
        ev_enter     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (irq_pend) begin
                    ev_accept = 1'b1;
                    nxt       = instr_busy ? ST_WAIT : ST_STACK;
                    nxt_cnt   = '0;
                end
            end
            ST_WAIT: begin
                if (!instr_busy) begin
                    nxt     = ST_STACK;
                    nxt_cnt = '0;
                end
            end
            ST_STACK: begin
                if (cnt == LAST_CTX) begin
                    ev_push_done = 1'b1;
                    nxt          = ST_FETCH;
                    nxt_cnt      = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            ST_FETCH: begin
                if (cnt == LAST_FETCH) begin
                    ev_enter = 1'b1;
                    nxt      = ST_RUN;
                    nxt_cnt  = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (hdl_ret) begin
                    nxt_cnt = '0;
                    if (irq_pend) begin
                        ev_accept = 1'b1;
                        nxt       = ST_CHAIN;
                    end else begin
                        nxt = ST_UNSTK;
                    end
                end else if (irq_pend && depth < DEPTH_TOP) begin
                    ev_accept = 1'b1;
                    nxt       = instr_busy ? ST_WAIT : ST_STACK;
                    nxt_cnt   = '0;
                end
            end
            ST_UNSTK: begin
                if (irq_pend) begin
                    ev_accept = 1'b1;
                    nxt       = ST_CHAIN;
                    nxt_cnt   = '0;
                end else if (cnt == LAST_CTX) begin
                    ev_pop_done = 1'b1;
                    nxt         = (depth == DEPTH_ONE) ? ST_IDLE : ST_RUN;
                    nxt_cnt     = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            ST_CHAIN: begin
                if (cnt == LAST_CHAIN) begin
                    ev_enter = 1'b1;
                    nxt      = ST_RUN;
                    nxt_cnt  = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            default: begin
                nxt     = ST_IDLE;
                nxt_cnt = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_seq_sp.sv
module irq_seq_sp #(
    parameter int          AW        = 16,
    parameter int          CTX_WORDS = 8,
    parameter logic [15:0] SP_INIT   = 16'h1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_push_done,
    input  logic          ev_pop_done,
    output logic [AW-1:0] sp
);

    localparam logic [AW-1:0] FRAME = AW'(CTX_WORDS);

    always_ff @(posedge clk) begin
        if (!rst_n)            sp <= AW'(SP_INIT);
        else if (ev_push_done) sp <= sp - FRAME;
        else if (ev_pop_done)  sp <= sp + FRAME;
    end

endmodule

// File: rtl/irq_seq_lat.sv
module irq_seq_lat #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_accept,
    input  logic             counting,
    output logic [LAT_W-1:0] lat_cnt
);

    localparam logic [LAT_W-1:0] LAT_TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)                              lat_cnt <= '0;
        else if (ev_accept)                      lat_cnt <= '0;
        else if (counting && lat_cnt != LAT_TOP) lat_cnt <= lat_cnt + 1'b1;
    end

endmodule

// File: rtl/irq_seq_port.sv
module irq_seq_port
    import irq_seq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int CTX_WORDS = 8,
    parameter int CW        = 4,
    parameter int IW        = 3
) (
    input  seq_state_e    state,
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] sp,
    input  logic [DW-1:0] ctx_wdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [IW-1:0] ctx_idx
);

    localparam logic [AW-1:0] FRAME = AW'(CTX_WORDS);

    always_comb begin
        mem_we    = (state == ST_STACK);
        mem_re    = (state == ST_UNSTK);
        mem_wdata = ctx_wdata;
        ctx_idx   = cnt[IW-1:0];
        if (mem_we) mem_addr = sp - FRAME + AW'(cnt);
        else        mem_addr = sp + AW'(cnt);
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          AW        = 16,
    parameter logic [15:0] SP_INIT   = 16'h1000,
    parameter int          CTX_WORDS = 8,
    parameter int          FETCH_CYC = 4,
    parameter int          CHAIN_CYC = 6,
    parameter int          NEST_MAX  = 4,
    parameter int          LAT_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          irq_pend,
    input  logic                          instr_busy,
    input  logic                          hdl_ret,
    input  logic [DW-1:0]                 ctx_wdata,
    output logic                          busy,
    output logic                          hdl_start,
    output logic [AW-1:0]                 sp,
    output logic [LAT_W-1:0]              lat_cnt,
    output logic [$clog2(NEST_MAX+1)-1:0] nest_depth,
    output logic [$clog2(CTX_WORDS)-1:0]  ctx_idx,
    output logic                          mem_we,
    output logic                          mem_re,
    output logic [AW-1:0]                 mem_addr,
    output logic [DW-1:0]                 mem_wdata
);

    localparam int MAXC_A = (CTX_WORDS > FETCH_CYC) ? CTX_WORDS : FETCH_CYC;
    localparam int MAXC   = (MAXC_A > CHAIN_CYC) ? MAXC_A : CHAIN_CYC;
    localparam int CW     = $clog2(MAXC + 1);
    localparam int DPW    = $clog2(NEST_MAX + 1);
    localparam int IW     = $clog2(CTX_WORDS);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          ev_accept, ev_push_done, ev_pop_done, counting;

    irq_seq_fsm #(
        .CTX_WORDS(CTX_WORDS), .FETCH_CYC(FETCH_CYC), .CHAIN_CYC(CHAIN_CYC),
        .NEST_MAX(NEST_MAX), .CW(CW), .DPW(DPW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .instr_busy(instr_busy),
        .hdl_ret(hdl_ret), .state(state), .cnt(cnt), .depth(nest_depth),
        .ev_accept(ev_accept), .ev_push_done(ev_push_done),
        .ev_pop_done(ev_pop_done), .hdl_start(hdl_start)
    );

    irq_seq_sp #(.AW(AW), .CTX_WORDS(CTX_WORDS), .SP_INIT(SP_INIT)) u_sp (
        .clk(clk), .rst_n(rst_n), .ev_push_done(ev_push_done),
        .ev_pop_done(ev_pop_done), .sp(sp)
    );

    assign counting = (state == ST_WAIT) || (state == ST_STACK) ||
                      (state == ST_FETCH) || (state == ST_CHAIN);

    irq_seq_lat #(.LAT_W(LAT_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept),
        .counting(counting), .lat_cnt(lat_cnt)
    );

    irq_seq_port #(
        .AW(AW), .DW(DW), .CTX_WORDS(CTX_WORDS), .CW(CW), .IW(IW)
    ) u_port (
        .state(state), .cnt(cnt), .sp(sp), .ctx_wdata(ctx_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .ctx_idx(ctx_idx)
    );

    assign busy = (state != ST_IDLE) && (state != ST_RUN);

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int AW        = 16,
    parameter int LAT_W     = 8,
    parameter int CTX_WORDS = 8,
    parameter int CHAIN_CYC = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             hdl_start,
    input logic [AW-1:0]    sp,
    input logic [LAT_W-1:0] lat_cnt,
    input logic             mem_we,
    input logic             mem_re,
    input logic [AW-1:0]    mem_addr
);

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R5

    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we && !mem_re) |=> $stable(sp)); // R4

    AST_PUSH_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we ##1 mem_we |-> mem_addr == $past(mem_addr) + AW'(1)); // R2

    AST_PUSH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((sp - mem_addr) <= AW'(CTX_WORDS)) && (sp != mem_addr)); // R8

    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |-> !busy && !mem_we && !mem_re); // R9

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |=> !hdl_start); // R9

    AST_MEM_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy); // R9

    AST_LAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_start |-> lat_cnt >= LAT_W'(CHAIN_CYC)); // R6

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .AW(AW), .LAT_W(LAT_W), .CTX_WORDS(CTX_WORDS), .CHAIN_CYC(CHAIN_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .hdl_start(hdl_start), .sp(sp),
    .lat_cnt(lat_cnt), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

    localparam int SP0 = 16'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_pend = 1'b0, instr_busy = 1'b0, hdl_ret = 1'b0;
    logic [31:0] ctx_wdata = 32'hC0DE_5A5A;
    logic        busy, hdl_start, mem_we, mem_re;
    logic [15:0] sp, mem_addr;
    logic [7:0]  lat_cnt;
    logic [2:0]  nest_depth;
    logic [2:0]  ctx_idx;
    logic [31:0] mem_wdata;

    always #5 clk = ~clk;

    irq_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .instr_busy(instr_busy),
        .hdl_ret(hdl_ret), .ctx_wdata(ctx_wdata), .busy(busy),
        .hdl_start(hdl_start), .sp(sp), .lat_cnt(lat_cnt),
        .nest_depth(nest_depth), .ctx_idx(ctx_idx), .mem_we(mem_we),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int total = 0, bad = 0;
    int we_n = 0, re_n = 0, start_n = 0;
    bit finished = 0;

    // behavioural reference: phase 0 idle,1 wait,2 push,3 fetch,4 run,5 pop,6 chain
    int ph = 0, k = 0, m_lat = 0;
    bit m_start = 0;
    int frames[$];

    function automatic int m_sp();
        return (frames.size() == 0) ? SP0 : frames[$];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; k = 0; m_lat = 0; m_start = 0; frames.delete();
        end else begin
            m_start = 0;
            case (ph)
                0: if (irq_pend) begin m_lat = 0; k = 0; ph = instr_busy ? 1 : 2; end
                1: begin m_lat++; if (!instr_busy) begin ph = 2; k = 0; end end
                2: begin
                    m_lat++;
                    if (k == 7) begin frames.push_back(m_sp() - 8); ph = 3; k = 0; end
                    else k++;
                end
                3: begin m_lat++; if (k == 3) begin ph = 4; m_start = 1; end else k++; end
                4: if (hdl_ret) begin
                       k = 0;
                       if (irq_pend) begin ph = 6; m_lat = 0; end else ph = 5;
                   end else if (irq_pend && frames.size() < 4) begin
                       m_lat = 0; k = 0; ph = instr_busy ? 1 : 2;
                   end
                5: if (irq_pend) begin ph = 6; k = 0; m_lat = 0; end
                   else if (k == 7) begin
                       void'(frames.pop_back()); ph = (frames.size() == 0) ? 0 : 4;
                   end else k++;
                6: begin m_lat++; if (k == 5) begin ph = 4; m_start = 1; end else k++; end
                default: ph = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit e_busy, e_we, e_re;
        int e_addr;
        e_busy = (ph != 0) && (ph != 4);
        e_we = (ph == 2);
        e_re = (ph == 5);
        e_addr = e_we ? (m_sp() - 8 + k) : (m_sp() + k);
        chk(busy == e_busy, "R9", "busy", busy, e_busy);
        chk(hdl_start == m_start, "R9", "hdl_start", hdl_start, m_start);
        chk(sp == m_sp(), "R4", "sp", sp, m_sp());
        chk(mem_we == e_we, "R2", "mem_we", mem_we, e_we);
        chk(mem_re == e_re, "R5", "mem_re", mem_re, e_re);
        chk(lat_cnt == m_lat, "R3", "lat_cnt", lat_cnt, m_lat);
        chk(nest_depth == frames.size(), "R8", "nest_depth", nest_depth, frames.size());
        if (e_we || e_re) begin
            chk(mem_addr == e_addr[15:0], "R2", "mem_addr", mem_addr, e_addr);
            chk(ctx_idx == k, "R2", "ctx_idx", ctx_idx, k);
        end
        if (e_we) chk(mem_wdata == ctx_wdata, "R2", "mem_wdata", mem_wdata, ctx_wdata);
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        if (mem_we) we_n++;
        if (mem_re) re_n++;
        if (hdl_start) start_n++;
    endtask

    task automatic clr();
        we_n = 0; re_n = 0; start_n = 0;
    endtask

    task automatic wait_start();
        for (int i = 0; i < 100; i++) begin
            step();
            if (hdl_start) break;
        end
        irq_pend = 1'b0;
    endtask

    task automatic do_return();
        hdl_ret = 1'b1;
        step();
        hdl_ret = 1'b0;
        for (int i = 0; i < 50 && busy; i++) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(busy == 0 && mem_we == 0 && mem_re == 0, "R1", "strobes", busy, 0);
        chk(sp == SP0, "R1", "sp", sp, SP0);
        chk(nest_depth == 0 && lat_cnt == 0, "R1", "depth/lat", nest_depth, 0);

        // R2 plain entry
        clr(); irq_pend = 1'b1; wait_start();
        chk(lat_cnt == 12, "R2", "entry latency", lat_cnt, 12);
        chk(we_n == 8, "R2", "push count", we_n, 8);
        chk(sp == SP0 - 8, "R4", "sp after push", sp, SP0 - 8);
        step();
        chk(hdl_start == 0, "R9", "start pulse width", hdl_start, 0);

        // R5 return to idle
        clr(); do_return();
        chk(re_n == 8, "R5", "pop count", re_n, 8);
        chk(sp == SP0 && nest_depth == 0, "R5", "sp after pop", sp, SP0);

        // R3 entry behind a multi-cycle instruction
        clr(); irq_pend = 1'b1; instr_busy = 1'b1;
        step(); step(); step();
        chk(we_n == 0, "R3", "no push while instr busy", we_n, 0);
        instr_busy = 1'b0;
        wait_start();
        chk(lat_cnt == 15, "R3", "stalled latency", lat_cnt, 15);

        // R6 tail-chain
        clr(); hdl_ret = 1'b1; irq_pend = 1'b1; step(); hdl_ret = 1'b0;
        wait_start();
        chk(lat_cnt == 6, "R6", "chain latency", lat_cnt, 6);
        chk(we_n == 0 && re_n == 0, "R6", "chain memory traffic", we_n + re_n, 0);
        chk(sp == SP0 - 8, "R6", "sp after chain", sp, SP0 - 8);

        // R7 request during pop
        clr(); hdl_ret = 1'b1; step(); hdl_ret = 1'b0; step(); step();
        irq_pend = 1'b1; wait_start();
        chk(lat_cnt == 6, "R7", "abandon latency", lat_cnt, 6);
        chk(sp == SP0 - 8 && nest_depth == 1, "R7", "sp kept", sp, SP0 - 8);
        do_return();

        // R8 nesting and LIFO pop
        irq_pend = 1'b1; wait_start();
        irq_pend = 1'b1; wait_start();
        chk(sp == SP0 - 16 && nest_depth == 2, "R8", "nested sp", sp, SP0 - 16);
        clr(); do_return();
        chk(start_n == 0 && nest_depth == 1, "R5", "resume without start", start_n, 0);
        chk(sp == SP0 - 8, "R8", "outer frame on top", sp, SP0 - 8);
        do_return();

        // R10 depth limit
        for (int n = 0; n < 4; n++) begin irq_pend = 1'b1; wait_start(); end
        clr(); irq_pend = 1'b1;
        repeat (6) step();
        irq_pend = 1'b0;
        chk(we_n == 0 && busy == 0, "R10", "pend ignored at max depth", we_n, 0);
        chk(nest_depth == 4, "R10", "depth at max", nest_depth, 4);
        for (int n = 0; n < 4; n++) do_return();
        chk(sp == SP0 && busy == 0, "R8", "all frames popped", sp, SP0);

        // R10 return while idle
        clr(); hdl_ret = 1'b1; repeat (3) step(); hdl_ret = 1'b0; step();
        chk(re_n == 0 && busy == 0, "R10", "ret ignored when idle", re_n, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule